// File: doc/BRIEF.md
# Add-On Pass-Through Response Sequencer

This block sits on the local side of a host bus bridge and answers single pass-through accesses. When the bridge raises its attention line, the sequencer captures the access status: burst flag, target region, direction and byte enables. In the same clock it strobes the bridge's address-fetch input and points chip select, offset and byte enables at the bridge's data register at offset 2Ch. It then moves one word between that register and a small local memory port that has a ready handshake. It finishes the access with a ready pulse.

The order of the bridge strobes depends on the direction. For a host write, the register is read with the read strobe and the word is then written to local memory. For a host read, a fixed number of idle turnaround clocks follows the address fetch. The local memory is then read, and the word is driven onto the bridge data bus with the write strobe and the ready pulse in the same clock. The data bus is a split output, output-enable and input set, so the chip level can build the tri-state pad.

Top module: `addon_pt_seq`

## Requirements
- R1: After reset every strobe (address fetch, read, write, ready, chip select, memory request) is low, the data output enable is low, the byte-enable outputs are all ones (active low, 4'hF) and the unsupported-access flag is clear.
- R2: The first rising edge that sees attention high samples the status. In the next clock, address fetch is high for exactly one clock, with chip select high, offset 6'h2C and the sampled active-low byte enables on the register byte-enable outputs.
- R3: For a host write (direction input 1), the read strobe is high in the clock after the address fetch, with chip select high and offset 6'h2C. The word on the data bus input in that clock is written to local memory with the memory write flag high.
- R4: For a host read (direction input 0), TURN_CYC clocks follow the address fetch with no read strobe, no write strobe, no output enable and no memory request. A memory read request follows these clocks.
- R5: For a host read, the write strobe, the ready pulse and the data output enable are high in the same clock, with the word returned by local memory on the data output. The output enable is low again in the next clock.
- R6: The memory request, address and write flag stay high and unchanged until the memory ready input is sampled high. Each clock of delay adds exactly one clock to the access.
- R7: Ready is a single-clock pulse. For a host write it comes in the clock after the memory ready is accepted. No new address fetch starts while attention stays high after that pulse.
- R8: If the burst status is sampled high, the sticky unsupported-access flag rises and stays high until reset. The access still completes as one transfer.
- R9: The memory address is the 2-bit region concatenated with fetched address bits [LOW_W+1:2] (word mode). The memory byte enables are the inverse of the sampled active-low byte enables.
- R10: At most one of address fetch, read strobe and write strobe is high in any clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| attn_i | input | 1 | Bridge attention, high while an access is pending |
| st_burst_i | input | 1 | Status: burst access |
| st_region_i | input | 2 | Status: target region |
| st_wr_i | input | 1 | Status: 1 = host write, 0 = host read |
| st_be_n_i | input | BE_W | Status: active-low byte enables |
| rbus_cs_o | output | 1 | Bridge register chip select |
| rbus_ofs_o | output | OFS_W | Bridge register offset |
| rbus_be_n_o | output | BE_W | Bridge register active-low byte enables |
| rbus_rd_o | output | 1 | Bridge register read strobe |
| rbus_wr_o | output | 1 | Bridge register write strobe |
| addr_fetch_o | output | 1 | Direct address-fetch strobe |
| done_o | output | 1 | Access ready pulse |
| dbus_i | input | DATA_W | Data bus from bridge |
| dbus_o | output | DATA_W | Data bus to bridge |
| dbus_oe_o | output | 1 | Data bus output enable |
| mem_req_o | output | 1 | Local memory request |
| mem_we_o | output | 1 | Local memory write flag |
| mem_addr_o | output | 2+LOW_W | Local memory word address |
| mem_be_o | output | BE_W | Local memory byte enables, active high |
| mem_wdata_o | output | DATA_W | Local memory write data |
| mem_rdata_i | input | DATA_W | Local memory read data |
| mem_rdy_i | input | 1 | Local memory ready |
| unsup_o | output | 1 | Sticky unsupported (burst) access flag |

## Verification
The hardest case to reach is a host read whose memory answers late. The bus turnaround gap, the held memory request and the single clock of output enable must then all line up against a ready pulse that arrives a variable number of clocks after the fetch. The bench's memory model picks a wait count for each access, from 0 to 6, and the bridge model times every strobe relative to the attention edge. Directed cases add a burst status, and attention held high for several clocks after the ready pulse to test for a re-trigger.

// File: rtl/addon_pt_pkg.sv
package addon_pt_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_FETCH,
      S_RDREG,
      S_TURN,
      S_MEM,
      S_DRIVE,
      S_DONE,
      S_DRAIN
   } pt_state_e;

   localparam logic [7:0] DATA_REG_OFS = 8'h2C;

endpackage

// File: rtl/addon_pt_status.sv
module addon_pt_status #(
   parameter int BE_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_i,
   input  logic            burst_i,
   input  logic [1:0]      region_i,
   input  logic            wr_i,
   input  logic [BE_W-1:0] be_n_i,
   output logic [1:0]      region_o,
   output logic            wr_o,
   output logic [BE_W-1:0] be_n_o,
   output logic            unsup_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         region_o <= '0;
         wr_o     <= 1'b0;
         be_n_o   <= '1;
         unsup_o  <= 1'b0;
      end else if (load_i) begin
         region_o <= region_i;
         wr_o     <= wr_i;
         be_n_o   <= be_n_i;
         unsup_o  <= unsup_o | burst_i;
      end
   end

   // R8
   unsup_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unsup_o |=> unsup_o);

   // R8
   unsup_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && burst_i) |=> unsup_o);

endmodule

// File: rtl/addon_pt_fsm.sv
module addon_pt_fsm
   import addon_pt_pkg::*;
#(
   parameter int TURN_CYC = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic attn_i,
   input  logic host_wr_i,
   input  logic mem_rdy_i,
   output logic load_o,
   output logic fetch_o,
   output logic cs_o,
   output logic rd_o,
   output logic wr_o,
   output logic oe_o,
   output logic done_o,
   output logic mem_req_o,
   output logic cap_addr_o,
   output logic cap_wdata_o,
   output logic cap_rdata_o
);

   localparam int TCW = (TURN_CYC < 2) ? 1 : $clog2(TURN_CYC);
   localparam logic [TCW-1:0] TURN_LAST = TCW'(TURN_CYC - 1);

   pt_state_e        state_q, state_d;
   logic [TCW-1:0]   turn_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         S_IDLE:  if (attn_i) state_d = S_FETCH;
         S_FETCH: state_d = host_wr_i ? S_RDREG : S_TURN;
         S_RDREG: state_d = S_MEM;
         S_TURN:  if (turn_q == TURN_LAST) state_d = S_MEM;
         S_MEM:   if (mem_rdy_i) state_d = host_wr_i ? S_DONE : S_DRIVE;
         S_DRIVE: state_d = S_DRAIN;
         S_DONE:  state_d = S_DRAIN;
         S_DRAIN: if (!attn_i) state_d = S_IDLE;
         default: state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         turn_q  <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == S_TURN) turn_q <= turn_q + 1'b1;
         else                   turn_q <= '0;
      end
   end

   assign load_o      = (state_q == S_IDLE) && attn_i;
   assign fetch_o     = (state_q == S_FETCH);
   assign rd_o        = (state_q == S_RDREG);
   assign wr_o        = (state_q == S_DRIVE);
   assign oe_o        = (state_q == S_DRIVE);
   assign done_o      = (state_q == S_DRIVE) || (state_q == S_DONE);
   assign mem_req_o   = (state_q == S_MEM);
   assign cs_o        = (state_q == S_FETCH) || (state_q == S_RDREG) || (state_q == S_TURN)
                      || ((state_q == S_MEM) && !host_wr_i) || (state_q == S_DRIVE);
   assign cap_addr_o  = (state_q == S_FETCH);
   assign cap_wdata_o = (state_q == S_RDREG);
   assign cap_rdata_o = (state_q == S_MEM) && mem_rdy_i && !host_wr_i;

   // R2
   fetch_after_attn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fetch_o) |-> $past(attn_i));

   // R4
   turn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_o |-> !$past(fetch_o));

   // R5
   oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe_o |=> !oe_o);

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R7
   no_retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !fetch_o);

   // R10
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({fetch_o, rd_o, wr_o}) <= 1);

endmodule

// File: rtl/addon_pt_datapath.sv
module addon_pt_datapath #(
   parameter int DATA_W    = 32,
   parameter int LOW_W     = 4,
   parameter bit WORD_ADDR = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cap_addr_i,
   input  logic                cap_wdata_i,
   input  logic                cap_rdata_i,
   input  logic [1:0]          region_i,
   input  logic [DATA_W-1:0]   dbus_i,
   input  logic [DATA_W-1:0]   mem_rdata_i,
   output logic [LOW_W+1:0]    mem_addr_o,
   output logic [DATA_W-1:0]   data_o
);

   logic [LOW_W-1:0] low_q;
   logic [LOW_W-1:0] low_sel;

   generate
      if (WORD_ADDR) begin : g_word
         assign low_sel = dbus_i[LOW_W+1:2];
      end else begin : g_byte
         assign low_sel = dbus_i[LOW_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_q  <= '0;
         data_o <= '0;
      end else begin
         if (cap_addr_i)       low_q  <= low_sel;
         if (cap_wdata_i)      data_o <= dbus_i;
         else if (cap_rdata_i) data_o <= mem_rdata_i;
      end
   end

   assign mem_addr_o = {region_i, low_q};

endmodule

// File: rtl/addon_pt_seq.sv
module addon_pt_seq
   import addon_pt_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int OFS_W     = 6,
   parameter int LOW_W     = 4,
   parameter int TURN_CYC  = 1,
   parameter bit WORD_ADDR = 1'b1,
   localparam int BE_W     = DATA_W / 8,
   localparam int MEM_AW   = LOW_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              attn_i,
   input  logic              st_burst_i,
   input  logic [1:0]        st_region_i,
   input  logic              st_wr_i,
   input  logic [BE_W-1:0]   st_be_n_i,
   output logic              rbus_cs_o,
   output logic [OFS_W-1:0]  rbus_ofs_o,
   output logic [BE_W-1:0]   rbus_be_n_o,
   output logic              rbus_rd_o,
   output logic              rbus_wr_o,
   output logic              addr_fetch_o,
   output logic              done_o,
   input  logic [DATA_W-1:0] dbus_i,
   output logic [DATA_W-1:0] dbus_o,
   output logic              dbus_oe_o,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [MEM_AW-1:0] mem_addr_o,
   output logic [BE_W-1:0]   mem_be_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   input  logic [DATA_W-1:0] mem_rdata_i,
   input  logic              mem_rdy_i,
   output logic              unsup_o
);

   initial begin
      param_chk: assert (DATA_W % 8 == 0 && DATA_W >= LOW_W + 2 && OFS_W >= 6
                         && OFS_W <= 8 && TURN_CYC >= 1 && LOW_W >= 1)
         else $error("addon_pt_seq: illegal parameter set");
   end

   logic            load, cs, cap_addr, cap_wdata, cap_rdata;
   logic [1:0]      region_q;
   logic            host_wr_q;
   logic [BE_W-1:0] be_n_q;
   logic [DATA_W-1:0] data_q;

   addon_pt_status #(.BE_W(BE_W)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load),
      .burst_i  (st_burst_i),
      .region_i (st_region_i),
      .wr_i     (st_wr_i),
      .be_n_i   (st_be_n_i),
      .region_o (region_q),
      .wr_o     (host_wr_q),
      .be_n_o   (be_n_q),
      .unsup_o  (unsup_o)
   );

   addon_pt_fsm #(.TURN_CYC(TURN_CYC)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .attn_i      (attn_i),
      .host_wr_i   (host_wr_q),
      .mem_rdy_i   (mem_rdy_i),
      .load_o      (load),
      .fetch_o     (addr_fetch_o),
      .cs_o        (cs),
      .rd_o        (rbus_rd_o),
      .wr_o        (rbus_wr_o),
      .oe_o        (dbus_oe_o),
      .done_o      (done_o),
      .mem_req_o   (mem_req_o),
      .cap_addr_o  (cap_addr),
      .cap_wdata_o (cap_wdata),
      .cap_rdata_o (cap_rdata)
   );

   addon_pt_datapath #(.DATA_W(DATA_W), .LOW_W(LOW_W), .WORD_ADDR(WORD_ADDR)) u_dp (
      .clk         (clk),
      .rst_n       (rst_n),
      .cap_addr_i  (cap_addr),
      .cap_wdata_i (cap_wdata),
      .cap_rdata_i (cap_rdata),
      .region_i    (region_q),
      .dbus_i      (dbus_i),
      .mem_rdata_i (mem_rdata_i),
      .mem_addr_o  (mem_addr_o),
      .data_o      (data_q)
   );

   assign rbus_cs_o   = cs;
   assign rbus_ofs_o  = cs ? DATA_REG_OFS[OFS_W-1:0] : '0;
   assign rbus_be_n_o = cs ? be_n_q : '1;
   assign mem_we_o    = host_wr_q;
   assign mem_be_o    = ~be_n_q;
   assign mem_wdata_o = data_q;
   assign dbus_o      = data_q;

   // R6
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_rdy_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

   // R5
   oe_has_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dbus_oe_o |-> (done_o && rbus_wr_o));

   // R3
   rd_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rbus_rd_o |-> (rbus_cs_o && $past(addr_fetch_o)));

endmodule

// File: tb/sim_addon_pt_seq.sv
`timescale 1ns/1ps
module sim_addon_pt_seq;

   localparam int TURN = 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        attn_i = 1'b0, st_burst_i = 1'b0, st_wr_i = 1'b0;
   logic [1:0]  st_region_i = '0;
   logic [3:0]  st_be_n_i = 4'hF;
   logic        rbus_cs_o, rbus_rd_o, rbus_wr_o, addr_fetch_o, done_o;
   logic [5:0]  rbus_ofs_o;
   logic [3:0]  rbus_be_n_o, mem_be_o;
   logic [31:0] dbus_i = '0, dbus_o, mem_wdata_o, mem_rdata_i = '0;
   logic        dbus_oe_o, mem_req_o, mem_we_o, mem_rdy_i = 1'b0, unsup_o;
   logic [5:0]  mem_addr_o;

   int checks = 0, errors = 0;
   int mem_waits = 0;
   logic [31:0] mem_arr [64];
   logic [5:0]  cur_ea;
   logic        cur_wr;
   logic [3:0]  cur_ben;
   logic        exp_unsup = 1'b0;

   always #10 clk = ~clk;

   addon_pt_seq #(.TURN_CYC(TURN)) u0 (
      .clk(clk), .rst_n(rst_n), .attn_i(attn_i), .st_burst_i(st_burst_i),
      .st_region_i(st_region_i), .st_wr_i(st_wr_i), .st_be_n_i(st_be_n_i),
      .rbus_cs_o(rbus_cs_o), .rbus_ofs_o(rbus_ofs_o), .rbus_be_n_o(rbus_be_n_o),
      .rbus_rd_o(rbus_rd_o), .rbus_wr_o(rbus_wr_o), .addr_fetch_o(addr_fetch_o),
      .done_o(done_o), .dbus_i(dbus_i), .dbus_o(dbus_o), .dbus_oe_o(dbus_oe_o),
      .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
      .mem_be_o(mem_be_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
      .mem_rdy_i(mem_rdy_i), .unsup_o(unsup_o)
   );

   function automatic logic [5:0] exp_addr(input logic [1:0] rg, input logic [31:0] a);
      return {rg, a[5:2]};
   endfunction

   function automatic logic [31:0] fill(input logic [5:0] a);
      return 32'h9E37_79B9 * (32'(a) + 32'd1);
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // local memory model with programmable wait states
   initial begin : mem_model
      bit busy = 1'b0;
      int cnt = 0;
      forever begin
         @(negedge clk);
         if (mem_rdy_i) begin
            mem_rdy_i = 1'b0;
            busy = 1'b0;
         end else if (mem_req_o) begin
            if (!busy) begin
               busy = 1'b1;
               cnt = mem_waits;
               chk(mem_addr_o == cur_ea, "R9 memory address", 32'(mem_addr_o), 32'(cur_ea));
               chk(mem_be_o == ~cur_ben, "R9 memory byte enables", 32'(mem_be_o), 32'(~cur_ben));
               chk(mem_we_o == cur_wr, "R3 memory write flag", 32'(mem_we_o), 32'(cur_wr));
            end else begin
               chk(mem_addr_o == cur_ea && mem_we_o == cur_wr, "R6 request held", 32'(mem_addr_o), 32'(cur_ea));
            end
            if (cnt == 0) begin
               if (mem_we_o) mem_arr[mem_addr_o] = mem_wdata_o;
               else          mem_rdata_i = mem_arr[mem_addr_o];
               mem_rdy_i = 1'b1;
            end else begin
               cnt--;
            end
         end else if (busy) begin
            chk(1'b0, "R6 request dropped before ready", 32'(mem_req_o), 32'd1);
            busy = 1'b0;
         end
      end
   end

   task automatic run_access(input logic [1:0] rg, input logic wr, input logic [3:0] ben,
                             input logic bst, input logic [31:0] haddr, input logic [31:0] hdata,
                             input int waits, input int hold);
      int fetch_at = -1;
      int done_at = -1;
      int exp_done;
      cur_ea = exp_addr(rg, haddr);
      cur_wr = wr;
      cur_ben = ben;
      mem_waits = waits;
      exp_unsup = exp_unsup | bst;
      exp_done = wr ? (4 + waits) : (3 + TURN + waits);
      @(negedge clk);
      st_region_i = rg; st_wr_i = wr; st_be_n_i = ben; st_burst_i = bst; attn_i = 1'b1;
      for (int i = 1; i < 60 && done_at < 0; i++) begin
         @(negedge clk);
         dbus_i = '0;
         chk($countones({addr_fetch_o, rbus_rd_o, rbus_wr_o}) <= 1, "R10 strobe exclusivity",
             32'({addr_fetch_o, rbus_rd_o, rbus_wr_o}), 32'd0);
         if (addr_fetch_o) begin
            fetch_at = i;
            chk(i == 1, "R2 fetch one clock after attention", 32'(i), 32'd1);
            chk(rbus_cs_o && rbus_ofs_o == 6'h2C, "R2 select and offset", 32'(rbus_ofs_o), 32'h2C);
            chk(rbus_be_n_o == ben, "R2 byte enables", 32'(rbus_be_n_o), 32'(ben));
            dbus_i = haddr;
         end else if (rbus_rd_o) begin
            chk(wr && i == 2, "R3 read strobe timing", 32'(i), 32'd2);
            chk(rbus_cs_o && rbus_ofs_o == 6'h2C, "R3 select and offset", 32'(rbus_ofs_o), 32'h2C);
            dbus_i = hdata;
         end else if (rbus_wr_o) begin
            chk(!wr && i == exp_done, "R4 write strobe timing", 32'(i), 32'(exp_done));
            chk(dbus_oe_o && dbus_o == fill(cur_ea), "R5 driven data", dbus_o, fill(cur_ea));
         end
         if (!wr && fetch_at > 0 && i > fetch_at && i <= fetch_at + TURN) begin
            chk(!rbus_rd_o && !rbus_wr_o && !dbus_oe_o && !mem_req_o, "R4 turnaround idle",
                32'({rbus_rd_o, rbus_wr_o, dbus_oe_o, mem_req_o}), 32'd0);
         end
         if (done_o) begin
            done_at = i;
            chk(i == exp_done, "R7 ready timing", 32'(i), 32'(exp_done));
            if (!wr) chk(rbus_wr_o && dbus_oe_o, "R5 ready with write strobe", 32'(rbus_wr_o), 32'd1);
         end
      end
      chk(done_at > 0, "R7 access completed", 32'(done_at), 32'(exp_done));
      @(negedge clk);
      chk(!done_o && !dbus_oe_o, "R5 R7 release after ready", 32'({done_o, dbus_oe_o}), 32'd0);
      for (int k = 0; k < hold; k++) begin
         @(negedge clk);
         chk(!addr_fetch_o && !mem_req_o, "R7 no re-trigger while attention held",
             32'(addr_fetch_o), 32'd0);
      end
      attn_i = 1'b0;
      st_burst_i = 1'b0;
      @(negedge clk);
      if (wr) chk(mem_arr[cur_ea] == hdata, "R3 word written to memory", mem_arr[cur_ea], hdata);
      chk(unsup_o == exp_unsup, "R8 unsupported flag", 32'(unsup_o), 32'(exp_unsup));
      if (wr) mem_arr[cur_ea] = fill(cur_ea);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd20240611));
      for (int a = 0; a < 64; a++) mem_arr[a] = fill(6'(a));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk({addr_fetch_o, rbus_rd_o, rbus_wr_o, done_o, rbus_cs_o, mem_req_o, dbus_oe_o, unsup_o} == '0,
          "R1 idle strobes", 32'({addr_fetch_o, rbus_rd_o, rbus_wr_o, done_o, rbus_cs_o, mem_req_o, dbus_oe_o, unsup_o}), 32'd0);
      chk(rbus_be_n_o == 4'hF, "R1 byte enables idle", 32'(rbus_be_n_o), 32'hF);

      // directed: minimum-time write and read, slow read, held attention
      run_access(2'd1, 1'b1, 4'h0, 1'b0, 32'h0000_0014, 32'hCAFE_0001, 0, 0);
      run_access(2'd1, 1'b0, 4'h0, 1'b0, 32'h0000_0014, 32'h0, 0, 0);
      run_access(2'd3, 1'b0, 4'h3, 1'b0, 32'h0000_003C, 32'h0, 6, 0);
      run_access(2'd2, 1'b1, 4'hC, 1'b0, 32'h0000_0020, 32'h1234_5678, 5, 4);
      run_access(2'd0, 1'b0, 4'h0, 1'b0, 32'h0000_0008, 32'h0, 2, 3);
      // R8 burst status, still one transfer
      run_access(2'd2, 1'b1, 4'h0, 1'b1, 32'h0000_0004, 32'hBEEF_0042, 1, 0);
      run_access(2'd1, 1'b0, 4'h0, 1'b0, 32'h0000_0030, 32'h0, 0, 0);

      for (int n = 0; n < 40; n++) begin
         run_access(2'($urandom), 1'($urandom), 4'($urandom), ($urandom % 8) == 0,
                    $urandom, $urandom, int'($urandom % 7), int'($urandom % 4));
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule